// File: doc/BRIEF.md
# Pseudo-Ternary Frame Line Encoder

This block turns a serial stream of 48-bit subscriber-loop frames into a three-level line code. The line level is carried by two strobes, one for a positive pulse and one for a negative pulse; when neither is set the line sits at zero volts. On every bit-clock enable the block accepts one frame bit together with a tag that tells whether the bit is the framing bit, the framing-balance bit or an ordinary bit.

A binary one produces no pulse. Zeros are sent as pulses whose polarity alternates. Two code violations are forced on purpose. The framing bit is always positive. The first zero after the balance bit repeats the polarity of the last pulse instead of inverting it. The running polarity follows every pulse actually sent, forced ones included. Each output level is held for the whole bit period (full-width pulses).

A 48-state bit counter marks the start of each frame. It also checks that the framing tag arrives only at bit 0, and latches a sticky flag when it does not. In normal use the bit enable comes from a 192 kHz tick, so one frame lasts 250 µs.

Top module: `st_line_encoder`

## Requirements
- R1: A bit with value 1 and tag 2'b00 (ordinary), 2'b10 (balance) or 2'b11 (reserved, handled as ordinary) drives neither pulse output for its bit period.
- R2: A zero with tag 2'b00 or 2'b11, when no balance exception is pending, is sent with the opposite polarity to the most recent pulse. The running polarity is updated after every pulse sent, forced ones included.
- R3: A bit tagged 2'b01 (framing) is always sent as a positive pulse, whatever its data value and whatever the running polarity.
- R4: Once a bit tagged 2'b10 has been accepted, the next zero tagged 2'b00, 2'b10 or 2'b11 is sent with the same polarity as the most recent pulse. Alternation then resumes.
- R5: While reset is asserted, and until the first accepted bit, both pulse outputs, the frame-start strobe and the alignment flag are low. The running polarity resets to negative, so the first ordinary zero after reset is sent positive.
- R6: Pulse outputs change only on the clock edge that accepts a bit (bit_en high). They hold their level on every other cycle.
- R7: The positive and negative outputs are never high together.
- R8: The bit counter starts at 0 after reset and advances on each accepted bit, wrapping from 47 to 0. frame_start_o is high for exactly the one cycle after the edge that accepts bit index 0.
- R9: The alignment flag is set when a framing tag is accepted at a bit index other than 0, or when a bit at index 0 is accepted without a framing tag. Once set, it stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_en | input | 1 | Bit-clock enable, one cycle per line bit |
| bit_in | input | 1 | Frame bit value |
| bit_tag | input | 2 | 00 ordinary, 01 framing, 10 balance, 11 ordinary |
| pos_o | output | 1 | Positive pulse strobe |
| neg_o | output | 1 | Negative pulse strobe |
| frame_start_o | output | 1 | One-cycle strobe after bit 0 is accepted |
| align_err_o | output | 1 | Sticky framing-position error |

## Verification
The assertions check the following on every cycle:
- the two strobes are never high together;
- a framing-tagged bit always produces a positive pulse, and a tagged one produces silence;
- the outputs hold between enables;
- the frame strobe follows an accepted bit;
- the alignment flag is sticky.

The polarity history cannot be seen in a single-cycle property, and neither can the exact frame position. The bench's scoreboard therefore covers alternation across pulses, the repeated polarity after the balance bit, the positive first zero after reset, the counter wrap over several frames and the error on a misplaced framing tag.

// File: rtl/st_enc_pkg.sv
package st_enc_pkg;

  typedef enum logic [1:0] {
    TAG_ORD = 2'b00,
    TAG_FRM = 2'b01,
    TAG_BAL = 2'b10,
    TAG_RSV = 2'b11
  } bit_tag_e;

  typedef struct packed {
    logic pos;
    logic neg;
  } line_sym_t;

  localparam line_sym_t SYM_ZERO = '{pos: 1'b0, neg: 1'b0};

endpackage

// File: rtl/st_rst_sync.sv
module st_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/st_frame_counter.sv
module st_frame_counter #(
  parameter int FRAME_BITS = 48,
  localparam int CNT_W = $clog2(FRAME_BITS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  output logic [CNT_W-1:0] idx,
  output logic             at_start
);

  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(FRAME_BITS - 1);

  logic [CNT_W-1:0] idx_q, idx_d;

  always_comb begin
    idx_d = idx_q;
    if (adv) begin
      if (idx_q == LAST_IDX) idx_d = '0;
      else                   idx_d = idx_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) idx_q <= '0;
    else        idx_q <= idx_d;
  end

  assign idx      = idx_q;
  assign at_start = (idx_q == '0);

endmodule

// File: rtl/st_polarity_unit.sv
module st_polarity_unit
  import st_enc_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      adv,
  input  logic      bit_in,
  input  bit_tag_e  tag,
  output line_sym_t sym
);

  line_sym_t sym_q, sym_d;
  logic      last_pos_q, last_pos_d;   // 1: last pulse positive
  logic      hold_q, hold_d;           // balance exception pending
  logic      use_pos;

  always_comb begin
    sym_d      = sym_q;
    last_pos_d = last_pos_q;
    hold_d     = hold_q;
    use_pos    = 1'b0;
    if (adv) begin
      sym_d = SYM_ZERO;
      if (tag == TAG_FRM) begin
        sym_d.pos  = 1'b1;
        last_pos_d = 1'b1;
      end else if (!bit_in) begin
        use_pos    = hold_q ? last_pos_q : !last_pos_q;
        sym_d.pos  = use_pos;
        sym_d.neg  = !use_pos;
        last_pos_d = use_pos;
        hold_d     = 1'b0;
      end
      if (tag == TAG_BAL) hold_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sym_q      <= SYM_ZERO;
      last_pos_q <= 1'b0;
      hold_q     <= 1'b0;
    end else begin
      sym_q      <= sym_d;
      last_pos_q <= last_pos_d;
      hold_q     <= hold_d;
    end
  end

  assign sym = sym_q;

endmodule

// File: rtl/st_align_monitor.sv
module st_align_monitor (
  input  logic clk,
  input  logic rst_n,
  input  logic adv,
  input  logic is_frm,
  input  logic at_start,
  output logic frame_start,
  output logic align_err
);

  logic fs_q, fs_d;
  logic err_q, err_d;

  always_comb begin
    fs_d  = adv && at_start;
    err_d = err_q || (adv && (is_frm != at_start));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fs_q  <= 1'b0;
      err_q <= 1'b0;
    end else begin
      fs_q  <= fs_d;
      err_q <= err_d;
    end
  end

  assign frame_start = fs_q;
  assign align_err   = err_q;

endmodule

// File: rtl/st_line_encoder.sv
module st_line_encoder
  import st_enc_pkg::*;
#(
  parameter int FRAME_BITS = 48,
  parameter int SYNC_STAGES = 2,
  localparam int CNT_W = $clog2(FRAME_BITS)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bit_en,
  input  logic       bit_in,
  input  logic [1:0] bit_tag,
  output logic       pos_o,
  output logic       neg_o,
  output logic       frame_start_o,
  output logic       align_err_o
);

  logic             rst_int_n;
  logic [CNT_W-1:0] bit_idx;
  logic             at_start;
  bit_tag_e         tag;
  line_sym_t        sym;

  assign tag = bit_tag_e'(bit_tag);

  st_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  st_frame_counter #(.FRAME_BITS(FRAME_BITS)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .adv      (bit_en),
    .idx      (bit_idx),
    .at_start (at_start)
  );

  st_polarity_unit u_pol (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .adv    (bit_en),
    .bit_in (bit_in),
    .tag    (tag),
    .sym    (sym)
  );

  st_align_monitor u_mon (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .adv         (bit_en),
    .is_frm      (tag == TAG_FRM),
    .at_start    (at_start),
    .frame_start (frame_start_o),
    .align_err   (align_err_o)
  );

  assign pos_o = sym.pos;
  assign neg_o = sym.neg;

  logic unused_idx;
  assign unused_idx = ^bit_idx;

endmodule

// File: rtl/st_line_encoder_chk.sv
module st_line_encoder_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       bit_en,
  input logic       bit_in,
  input logic [1:0] bit_tag,
  input logic       pos_o,
  input logic       neg_o,
  input logic       frame_start_o,
  input logic       align_err_o
);

  assert_one_hot_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(pos_o && neg_o));

  assert_frm_positive_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_en && bit_tag == 2'b01) |=> (pos_o && !neg_o));

  assert_one_silent_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_en && bit_in && bit_tag != 2'b01) |=> (!pos_o && !neg_o));

  assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_en |=> ($stable(pos_o) && $stable(neg_o)));

  assert_err_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    align_err_o |=> align_err_o);

  assert_fs_after_en_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(frame_start_o) |-> $past(bit_en));

endmodule

bind st_line_encoder st_line_encoder_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .bit_en        (bit_en),
  .bit_in        (bit_in),
  .bit_tag       (bit_tag),
  .pos_o         (pos_o),
  .neg_o         (neg_o),
  .frame_start_o (frame_start_o),
  .align_err_o   (align_err_o)
);

// File: tb/st_line_encoder_bench.sv
module st_line_encoder_bench;

  logic       clk;
  logic       rst_n;
  logic       bit_en;
  logic       bit_in;
  logic [1:0] bit_tag;
  logic       pos_o, neg_o, frame_start_o, align_err_o;

  int checks;
  int errors;
  bit running;
  bit done;

  typedef struct {
    logic  p;
    logic  n;
    logic  fs;
    logic  err;
    string req;
  } exp_t;

  exp_t exp_q[$];
  exp_t last_exp;

  // reference model state
  int   m_cnt;
  logic m_pos_last;
  logic m_pend;
  logic m_err;
  bit   m_first_zero;

  st_line_encoder u_st_line_encoder (
    .clk           (clk),
    .rst_n         (rst_n),
    .bit_en        (bit_en),
    .bit_in        (bit_in),
    .bit_tag       (bit_tag),
    .pos_o         (pos_o),
    .neg_o         (neg_o),
    .frame_start_o (frame_start_o),
    .align_err_o   (align_err_o)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check1(input string req, input logic act, input logic exp_v, input string what);
    checks++;
    if (act !== exp_v) begin
      errors++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp_v);
    end
  endtask

  task automatic send_bit(input logic b, input logic [1:0] tag, input int gap);
    exp_t e;
    logic use_pos;
    e.fs = (m_cnt == 0);
    if ((tag == 2'b01) != (m_cnt == 0)) m_err = 1'b1;
    e.p = 1'b0; e.n = 1'b0;
    if (tag == 2'b01) begin
      e.p = 1'b1; m_pos_last = 1'b1; e.req = "R3";
    end else if (b == 1'b0) begin
      if (m_pend) begin
        use_pos = m_pos_last; e.req = "R4";
      end else begin
        use_pos = !m_pos_last; e.req = m_first_zero ? "R5" : "R2";
      end
      m_first_zero = 1'b0;
      m_pend = 1'b0;
      e.p = use_pos; e.n = !use_pos; m_pos_last = use_pos;
    end else begin
      e.req = "R1";
    end
    if (tag == 2'b10) m_pend = 1'b1;
    e.err = m_err;
    m_cnt = (m_cnt == 47) ? 0 : m_cnt + 1;

    @(negedge clk);
    bit_in = b; bit_tag = tag; bit_en = 1'b1;
    @(posedge clk);
    #1;
    exp_q.push_back(e);
    @(negedge clk);
    bit_en = 1'b0;
    repeat (gap) @(negedge clk);
  endtask

  // monitor: compares at each falling edge
  always @(negedge clk) begin
    if (running) begin
      if (exp_q.size() > 0) begin
        exp_t e;
        e = exp_q.pop_front();
        check1(e.req, pos_o, e.p, "pos");
        check1(e.req, neg_o, e.n, "neg");
        check1("R8", frame_start_o, e.fs, "frame_start");
        check1("R9", align_err_o, e.err, "align_err");
        last_exp = e;
      end else begin
        check1("R6", pos_o, last_exp.p, "pos hold");
        check1("R6", neg_o, last_exp.n, "neg hold");
        check1("R8", frame_start_o, 1'b0, "frame_start idle");
        check1("R7", logic'(pos_o && neg_o), 1'b0, "both high");
      end
    end
  end

  task automatic send_frame(input int seed, input int gap);
    for (int i = 0; i < 48; i++) begin
      logic [1:0] t;
      logic b;
      t = (i == 0) ? 2'b01 : (i == 1) ? 2'b10 : ((i % 11) == 5) ? 2'b11 : 2'b00;
      b = (((i * 7 + seed) % 3) == 0) ? 1'b1 : 1'b0;
      send_bit(b, t, gap);
    end
  endtask

  initial begin
    checks = 0; errors = 0; running = 1'b0; done = 1'b0;
    bit_en = 1'b0; bit_in = 1'b1; bit_tag = 2'b00;
    m_cnt = 0; m_pos_last = 1'b0; m_pend = 1'b0; m_err = 1'b0; m_first_zero = 1'b1;
    last_exp.p = 1'b0; last_exp.n = 1'b0; last_exp.fs = 1'b0; last_exp.err = 1'b0; last_exp.req = "R5";
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    check1("R5", pos_o, 1'b0, "pos in reset");
    check1("R5", neg_o, 1'b0, "neg in reset");
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check1("R5", pos_o, 1'b0, "pos after reset");
    check1("R5", neg_o, 1'b0, "neg after reset");
    check1("R5", frame_start_o, 1'b0, "frame_start after reset");
    check1("R5", align_err_o, 1'b0, "align_err after reset");
    running = 1'b1;

    // R3 framing bit with value 1, R5 first zero positive, R1 ones
    send_bit(1'b1, 2'b01, 2);
    send_bit(1'b1, 2'b10, 2);
    send_bit(1'b0, 2'b00, 2);   // R4: repeats positive
    send_bit(1'b0, 2'b00, 2);   // R2: negative
    send_bit(1'b1, 2'b00, 2);   // R1
    send_bit(1'b0, 2'b11, 2);   // R2: positive
    for (int i = 6; i < 48; i++) send_bit(1'b0, 2'b00, 0);
    // frames with mixed data, back-to-back and with gaps
    send_frame(1, 0);
    send_frame(2, 3);
    send_frame(0, 1);
    // zero balance bit then zeros
    send_bit(1'b0, 2'b01, 1);
    send_bit(1'b0, 2'b10, 1);
    send_bit(1'b0, 2'b00, 1);
    send_bit(1'b0, 2'b00, 1);
    // R9: misplaced framing tag, then error stays set
    send_bit(1'b0, 2'b01, 1);
    for (int i = 5; i < 48; i++) send_bit(1'b1, 2'b00, 0);
    send_bit(1'b0, 2'b01, 2);
    send_bit(1'b0, 2'b00, 2);
    repeat (3) @(negedge clk);
    running = 1'b0;
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule